// File: doc/BRIEF.md
# PWM Input Capture Unit

This block measures the period and the high time of an external pulse train. One of two input pins is chosen, passed through a synchronizer, and watched by two capture units that both sample a shared free-running counter. The first unit records the counter on rising edges. The second records it on falling edges. Both units can be told to act only on every 2nd, 4th or 8th qualifying edge.

Each rising-edge capture presents a snapshot of both capture registers on a readout port. After a start pulse, the block takes the first snapshot as the reference time. It takes the second snapshot as the closing rising time and the latest falling time. From these three values it computes a period count and a duty count, correcting for counter wraparound and for the edge prescaler. Configuration arrives as plain register-style inputs, and a clock-enable input qualifies the counter's clock.

Top module: `pwm_capture_unit`

## Requirements
- R1: `cfg_pin_sel_i` = 0 feeds pin A to both capture units and 1 feeds pin B. Pulses on the unselected pin produce no snapshot.
- R2: The rising-edge unit latches the counter on a synchronized rising edge and the falling-edge unit latches it on a falling edge. With the edge prescaler at 0 and no wrap, the duty result equals the high time in counter ticks.
- R3: With edge prescaler code N (0..3), each unit captures on every 2^N-th qualifying edge. With no wrap, successive rising snapshots are (period × 2^N) ticks apart.
- R4: Every rising-edge capture raises `snap_valid_o` for exactly one cycle. While it is high, `snap_rise_o` holds the new rising capture and `snap_fall_o` holds the current falling capture.
- R5: The period is t2 − t0 when t0 ≤ t2, and otherwise reload − t0 + t2. Here t0 is the first rising snapshot after start and t2 is the second.
- R6: The duty is the same wrap-corrected difference from t0 to t1, where t1 is the falling value in the second snapshot. If it exceeds the period, the period is subtracted once.
- R7: When N ≠ 0 and the duty is at least period >> N, the duty becomes (period >> N) − (period − duty).
- R8: The counter counts 0..`cfg_reload_i` and then returns to 0. It advances once per (`cfg_clk_psc_i` + 1) cycles in which `cnt_tick_i` is high and `cfg_cnt_en_i` is set, and it holds while the counter enable is clear.
- R9: While `cfg_cap_en_i` is clear, no capture or snapshot happens. Clearing it, or clearing `cfg_cnt_en_i`, abandons a measurement in progress, so `done_o` does not rise.
- R10: The selected pin passes through two flip-flops before edge detection. A rising pin change shows up as `snap_valid_o` after the third rising clock edge.
- R11: `done_o` rises one cycle after the second snapshot that follows a start. The period and duty then hold until the next start, and a start clears `done_o`. A start in the same cycle as a snapshot wins, and that snapshot is not used.
- R12: The edge-prescaler counters of both units return to zero while `cfg_cap_en_i` is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_a_i | input | 1 | Pulse input A |
| pin_b_i | input | 1 | Pulse input B |
| cnt_tick_i | input | 1 | Clock enable for the counter timebase |
| cfg_pin_sel_i | input | 1 | Input select: 0 = A, 1 = B |
| cfg_cnt_en_i | input | 1 | Counter enable |
| cfg_cap_en_i | input | 1 | Capture enable for both units |
| cfg_edge_psc_i | input | 2 | Edge prescaler code N (every 2^N edges) |
| cfg_clk_psc_i | input | PSC_W | Counter clock divider minus one |
| cfg_reload_i | input | CNT_W | Counter top value |
| meas_start_i | input | 1 | One-cycle start of a measurement |
| snap_valid_o | output | 1 | Snapshot strobe on each rising capture |
| snap_rise_o | output | CNT_W | Rising capture register |
| snap_fall_o | output | CNT_W | Falling capture register |
| done_o | output | 1 | Measurement complete |
| period_o | output | CNT_W | Period in counter ticks |
| duty_o | output | CNT_W | High time in counter ticks |

## Verification
The start of a new measurement and the arrival of a snapshot can fall in the same cycle. The bench observes one snapshot, counts exactly one input period to place a start pulse on the cycle the next snapshot is presented, and confirms that the strobe is indeed high there. It then judges the outcome at the ports. `done_o` must still be low a few cycles after the first later snapshot. The final period and duty must match the two snapshots that followed the start, which shows that the colliding snapshot was discarded.

// File: rtl/pwmcap_pkg.sv
package pwmcap_pkg;
   localparam int EPSC_W     = 2;
   localparam int EDGE_CNT_W = 3;

   typedef enum logic [1:0] {
      MS_IDLE,
      MS_WAIT_REF,
      MS_WAIT_CLOSE
   } meas_st_e;
endpackage

// File: rtl/pwmcap_timebase.sv
module pwmcap_timebase #(
   parameter int CNT_W = 16,
   parameter int PSC_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic             tick_i,
   input  logic [PSC_W-1:0] psc_i,
   input  logic [CNT_W-1:0] reload_i,
   output logic [CNT_W-1:0] cnt_o
);
   logic [PSC_W-1:0] div_q;
   logic [CNT_W-1:0] cnt_q;
   logic             adv;

   assign adv   = run_i && tick_i && (div_q >= psc_i);
   assign cnt_o = cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         div_q <= '0;
         cnt_q <= '0;
      end else if (adv) begin
         div_q <= '0;
         cnt_q <= (cnt_q >= reload_i) ? '0 : cnt_q + 1'b1;
      end else if (run_i && tick_i) begin
         div_q <= div_q + 1'b1;
      end
   end

   // R8: a stopped counter keeps its value
   p_cnt_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_i |=> $stable(cnt_q))
      else $error("counter moved while disabled");
endmodule

// File: rtl/pwmcap_sync_edge.sv
module pwmcap_sync_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic pin_i,
   output logic rise_o,
   output logic fall_o
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   cur;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   assign cur    = sync_q[SYNC_STAGES-1];
   assign rise_o = cur && !prev_q;
   assign fall_o = !cur && prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
         prev_q <= cur;
      end
   end
endmodule

// File: rtl/pwmcap_channel.sv
module pwmcap_channel
   import pwmcap_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              en_i,
   input  logic              edge_i,
   input  logic [EPSC_W-1:0] epsc_i,
   input  logic [CNT_W-1:0]  cnt_i,
   output logic              fire_o,
   output logic [CNT_W-1:0]  ccr_o
);
   logic [EDGE_CNT_W-1:0] ecnt_q;
   logic [EDGE_CNT_W-1:0] last_cnt;
   logic [CNT_W-1:0]      ccr_q;

   assign last_cnt = EDGE_CNT_W'((32'd1 << epsc_i) - 32'd1);
   assign fire_o   = en_i && edge_i && (ecnt_q == last_cnt);
   assign ccr_o    = ccr_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ecnt_q <= '0;
      end else if (!en_i) begin
         ecnt_q <= '0;
      end else if (edge_i) begin
         ecnt_q <= (ecnt_q == last_cnt) ? '0 : ecnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     ccr_q <= '0;
      else if (fire_o) ccr_q <= cnt_i;
   end

   // R12: edge divider restarts while capture is disabled
   p_epsc_clear_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> (ecnt_q == '0))
      else $error("edge prescaler not cleared");
endmodule

// File: rtl/pwmcap_calc.sv
module pwmcap_calc
   import pwmcap_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic [CNT_W-1:0]  t0_i,
   input  logic [CNT_W-1:0]  t1_i,
   input  logic [CNT_W-1:0]  t2_i,
   input  logic [CNT_W-1:0]  reload_i,
   input  logic [EPSC_W-1:0] epsc_i,
   output logic [CNT_W-1:0]  period_o,
   output logic [CNT_W-1:0]  duty_o
);
   function automatic logic [CNT_W-1:0] gap(input logic [CNT_W-1:0] a,
                                            input logic [CNT_W-1:0] b,
                                            input logic [CNT_W-1:0] top);
      return (a <= b) ? (b - a) : (top - a + b);
   endfunction

   logic [CNT_W-1:0] per, d_raw, d_fix, per_sh;

   always_comb begin
      per    = gap(t0_i, t2_i, reload_i);
      d_raw  = gap(t0_i, t1_i, reload_i);
      d_fix  = (d_raw > per) ? d_raw - per : d_raw;
      per_sh = per >> epsc_i;
      period_o = per;
      duty_o   = d_fix;
      if (epsc_i != '0 && d_fix >= per_sh) duty_o = per_sh - (per - d_fix);
   end
endmodule

// File: rtl/pwm_capture_unit.sv
module pwm_capture_unit
   import pwmcap_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int PSC_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              pin_a_i,
   input  logic              pin_b_i,
   input  logic              cnt_tick_i,
   input  logic              cfg_pin_sel_i,
   input  logic              cfg_cnt_en_i,
   input  logic              cfg_cap_en_i,
   input  logic [1:0]        cfg_edge_psc_i,
   input  logic [PSC_W-1:0]  cfg_clk_psc_i,
   input  logic [CNT_W-1:0]  cfg_reload_i,
   input  logic              meas_start_i,
   output logic              snap_valid_o,
   output logic [CNT_W-1:0]  snap_rise_o,
   output logic [CNT_W-1:0]  snap_fall_o,
   output logic              done_o,
   output logic [CNT_W-1:0]  period_o,
   output logic [CNT_W-1:0]  duty_o
);
   localparam int N_UNITS = 2;

   if (CNT_W < 4 || CNT_W > 32) begin : g_bad_cnt
      $error("CNT_W out of range 4..32");
   end
   if (PSC_W < 1 || PSC_W > 32) begin : g_bad_psc
      $error("PSC_W out of range 1..32");
   end
   if (EPSC_W != 2) begin : g_bad_epsc
      $error("edge prescaler port expects a 2-bit code");
   end

   logic                 sel_pin, rise_w, fall_w;
   logic [CNT_W-1:0]     cnt_w;
   logic [N_UNITS-1:0]   edge_v, fire_w;
   logic [CNT_W-1:0]     ccr_w [N_UNITS];
   logic                 snap_q;
   meas_st_e             st_q;
   logic [CNT_W-1:0]     t0_q, per_w, duty_w, per_q, duty_q;
   logic                 done_q;

   assign sel_pin = cfg_pin_sel_i ? pin_b_i : pin_a_i;

   pwmcap_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (sel_pin),
      .rise_o (rise_w),
      .fall_o (fall_w)
   );

   pwmcap_timebase #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_tb (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (cfg_cnt_en_i),
      .tick_i   (cnt_tick_i),
      .psc_i    (cfg_clk_psc_i),
      .reload_i (cfg_reload_i),
      .cnt_o    (cnt_w)
   );

   // unit 0 captures rising edges, unit 1 falling edges
   assign edge_v = {fall_w, rise_w};

   for (genvar g = 0; g < N_UNITS; g++) begin : g_unit
      pwmcap_channel #(.CNT_W(CNT_W)) u_ch (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .en_i   (cfg_cap_en_i),
         .edge_i (edge_v[g]),
         .epsc_i (cfg_edge_psc_i),
         .cnt_i  (cnt_w),
         .fire_o (fire_w[g]),
         .ccr_o  (ccr_w[g])
      );
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) snap_q <= 1'b0;
      else         snap_q <= fire_w[0];
   end

   assign snap_valid_o = snap_q;
   assign snap_rise_o  = ccr_w[0];
   assign snap_fall_o  = ccr_w[1];

   pwmcap_calc #(.CNT_W(CNT_W)) u_calc (
      .t0_i     (t0_q),
      .t1_i     (ccr_w[1]),
      .t2_i     (ccr_w[0]),
      .reload_i (cfg_reload_i),
      .epsc_i   (cfg_edge_psc_i),
      .period_o (per_w),
      .duty_o   (duty_w)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q   <= MS_IDLE;
         t0_q   <= '0;
         per_q  <= '0;
         duty_q <= '0;
         done_q <= 1'b0;
      end else if (meas_start_i) begin
         st_q   <= MS_WAIT_REF;
         done_q <= 1'b0;
      end else if (!cfg_cap_en_i || !cfg_cnt_en_i) begin
         st_q <= MS_IDLE;
      end else if (snap_q) begin
         unique case (st_q)
            MS_WAIT_REF: begin
               t0_q <= ccr_w[0];
               st_q <= MS_WAIT_CLOSE;
            end
            MS_WAIT_CLOSE: begin
               per_q  <= per_w;
               duty_q <= duty_w;
               done_q <= 1'b1;
               st_q   <= MS_IDLE;
            end
            default: st_q <= MS_IDLE;
         endcase
      end
   end

   assign done_o   = done_q;
   assign period_o = per_q;
   assign duty_o   = duty_q;

   // R4: snapshot strobe lasts one cycle
   p_snap_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      snap_valid_o |=> !snap_valid_o)
      else $error("snapshot strobe longer than one cycle");

   // R2: rising and falling captures never coincide
   p_unit_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(fire_w))
      else $error("both capture units fired together");

   // R9: no snapshot follows a cycle with capture disabled
   p_cap_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cfg_cap_en_i |=> !snap_valid_o)
      else $error("snapshot while capture disabled");

   // R11: completion only follows a snapshot
   p_done_src_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(done_o) |-> $past(snap_valid_o))
      else $error("done without snapshot");

   // R11: results hold until a new start
   p_res_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && !meas_start_i) |=> (done_o && $stable(period_o) && $stable(duty_o)))
      else $error("results changed before restart");
endmodule

// File: tb/pwm_capture_unit_tb_top.sv
module pwm_capture_unit_tb_top;
   localparam int CNT_W = 16;
   localparam int PSC_W = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic man_a = 1'b0, gen_pin = 1'b0, gen_on = 1'b0, gen_sel = 1'b0;
   logic tick_mode = 1'b0, tick = 1'b1;
   int   gen_hi = 4, gen_lo = 4;
   logic pin_a, pin_b;
   logic cfg_sel = 1'b0, cfg_cnt_en = 1'b1, cfg_cap_en = 1'b1, meas_start = 1'b0;
   logic [1:0] cfg_epsc = 2'd0;
   logic [PSC_W-1:0] cfg_cpsc = '0;
   logic [CNT_W-1:0] cfg_rel = 16'hFFFF;

   logic             snap_valid, done;
   logic [CNT_W-1:0] snap_rise, snap_fall, period, duty;

   assign pin_a = (gen_on && !gen_sel) ? gen_pin : man_a;
   assign pin_b = (gen_on && gen_sel) ? gen_pin : 1'b0;

   pwm_capture_unit #(.CNT_W(CNT_W), .PSC_W(PSC_W)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .pin_a_i(pin_a), .pin_b_i(pin_b),
      .cnt_tick_i(tick), .cfg_pin_sel_i(cfg_sel), .cfg_cnt_en_i(cfg_cnt_en),
      .cfg_cap_en_i(cfg_cap_en), .cfg_edge_psc_i(cfg_epsc), .cfg_clk_psc_i(cfg_cpsc),
      .cfg_reload_i(cfg_rel), .meas_start_i(meas_start), .snap_valid_o(snap_valid),
      .snap_rise_o(snap_rise), .snap_fall_o(snap_fall), .done_o(done),
      .period_o(period), .duty_o(duty));

   int vecs = 0, fails = 0;
   int meas_n = 0, snap_total = 0;
   logic [CNT_W-1:0] rec_r [2];
   logic [CNT_W-1:0] rec_f [2];

   // pulse and tick generator, drives at the falling clock edge
   initial begin
      int ph;
      ph = 0;
      forever begin
         @(negedge clk);
         tick = tick_mode ? ~tick : 1'b1;
         if (gen_on) begin
            gen_pin = (ph < gen_hi);
            ph = (ph + 1 >= gen_hi + gen_lo) ? 0 : ph + 1;
         end else begin
            ph = 0;
            gen_pin = 1'b0;
         end
      end
   end

   // snapshot monitor: values seen here are those the design uses at the next edge
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (snap_valid) snap_total++;
         if (meas_start) meas_n = 0;
         else if (snap_valid && meas_n < 2) begin
            rec_r[meas_n] = snap_rise;
            rec_f[meas_n] = snap_fall;
            meas_n++;
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vecs++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic [CNT_W-1:0] gap_m(input logic [CNT_W-1:0] a, b, top);
      return (a <= b) ? b - a : top - a + b;
   endfunction

   function automatic logic [CNT_W-1:0] exp_per(input logic [CNT_W-1:0] t0, t2, top);
      return gap_m(t0, t2, top);
   endfunction

   function automatic logic [CNT_W-1:0] exp_duty(input logic [CNT_W-1:0] t0, t1, t2, top,
                                                 input int n);
      logic [CNT_W-1:0] p, d, s;
      p = gap_m(t0, t2, top);
      d = gap_m(t0, t1, top);
      if (d > p) d = d - p;
      s = p >> n;
      if (n != 0 && d >= s) d = s - (p - d);
      return d;
   endfunction

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_start();
      @(negedge clk);
      meas_start = 1'b1;
      @(negedge clk);
      meas_start = 1'b0;
   endtask

   task automatic wait_done(input string tag);
      for (int i = 0; i < 30000; i++) begin
         @(negedge clk);
         #1;
         if (done) return;
      end
      chk({tag, " done timeout"}, 32'(done), 32'd1);
   endtask

   task automatic run_meas(input int h, l, n, psc, rel, sel, tm, input string tag);
      int per_cyc, div;
      @(negedge clk);
      gen_on = 1'b0;
      cyc(4);
      gen_hi = h; gen_lo = l; gen_sel = sel[0]; cfg_sel = sel[0];
      cfg_epsc = 2'(n); cfg_cpsc = PSC_W'(psc); cfg_rel = CNT_W'(rel);
      tick_mode = tm[0]; cfg_cap_en = 1'b1; cfg_cnt_en = 1'b1;
      gen_on = 1'b1;
      cyc(3);
      pulse_start();
      wait_done(tag);
      chk({tag, " R5 period"}, 32'(period), 32'(exp_per(rec_r[0], rec_r[1], cfg_rel)));
      chk({tag, " R6 R7 duty"}, 32'(duty),
          32'(exp_duty(rec_r[0], rec_f[1], rec_r[1], cfg_rel, n)));
      per_cyc = (h + l) << n;
      div = (psc + 1) * (tm ? 2 : 1);
      if (per_cyc % div == 0 && per_cyc / div <= rel) begin
         if (rec_r[1] >= rec_r[0])
            chk({tag, " R3 R8 true period"}, 32'(period), 32'(per_cyc / div));
         else
            chk({tag, " R5 wrapped period"}, 32'(period), 32'(per_cyc / div - 1));
      end
      if (n == 0 && div == 1 && per_cyc <= rel)
         chk({tag, " R2 true duty"}, 32'(duty), 32'((rec_f[1] >= rec_r[0]) ? h : h - 1));
   endtask

   task automatic man_pulse();
      @(negedge clk);
      man_a = 1'b1;
      cyc(4);
      man_a = 1'b0;
      cyc(4);
   endtask

   bit finished = 1'b0;

   initial begin
      #(4 * 190000);
      if (!finished) begin
         fails++;
         vecs++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
         $finish;
      end
   end

   initial begin
      int base, seen;
      void'($urandom(32'd2024));
      cyc(3);
      #1;
      chk("R11 reset done", 32'(done), 0);
      chk("R4 reset snap", 32'(snap_valid), 0);
      chk("R5 reset period", 32'(period), 0);
      @(negedge clk);
      rst_n = 1'b1;
      cyc(5);

      // R10: synchronizer latency from pin to snapshot strobe
      @(negedge clk);
      man_a = 1'b1;
      for (int k = 1; k <= 3; k++) begin
         @(negedge clk);
         #1;
         chk($sformatf("R10 latency step %0d", k), 32'(snap_valid), 32'(k == 3));
      end
      cyc(4);
      man_a = 1'b0;
      cyc(6);

      run_meas(10, 6, 0, 0, 16'hFFFF, 0, 0, "R2 basic pin A");
      run_meas(7, 12, 0, 0, 16'hFFFF, 1, 0, "R1 pin B");

      // R1: pulses on the unselected pin produce nothing
      @(negedge clk);
      gen_on = 1'b0; cyc(4);
      gen_sel = 1'b1; cfg_sel = 1'b0; gen_on = 1'b1;
      cyc(4);
      base = snap_total;
      cyc(200);
      chk("R1 unselected pin ignored", 32'(snap_total - base), 0);

      run_meas(5, 9, 2, 0, 16'hFFFF, 0, 0, "R3 edge psc 4");
      run_meas(9, 14, 0, 0, 40, 0, 0, "R5 wrap a");
      run_meas(13, 11, 0, 0, 40, 0, 0, "R5 wrap b");
      run_meas(6, 10, 1, 0, 37, 1, 0, "R6 wrap edge psc");
      run_meas(10, 8, 0, 1, 16'hFFFF, 0, 0, "R8 clock psc");
      run_meas(11, 9, 0, 0, 16'hFFFF, 0, 1, "R8 tick enable");
      run_meas(12, 5, 1, 0, 16'hFFFF, 0, 0, "R7 edge psc 2");
      run_meas(3, 20, 3, 0, 16'hFFFF, 1, 0, "R7 edge psc 8");

      // R11: results hold while pulses continue
      begin
         logic [CNT_W-1:0] p_hold, d_hold;
         p_hold = period; d_hold = duty;
         cyc(150);
         #1;
         chk("R11 done held", 32'(done), 1);
         chk("R11 period held", 32'(period), 32'(p_hold));
         chk("R11 duty held", 32'(duty), 32'(d_hold));
         pulse_start();
         #1;
         chk("R11 start clears done", 32'(done), 0);
      end

      // R9: capture disabled gives no snapshot and aborts a measurement
      @(negedge clk);
      cfg_cap_en = 1'b0;
      cyc(3);
      base = snap_total;
      cyc(200);
      chk("R9 no snapshot when disabled", 32'(snap_total - base), 0);
      cfg_cap_en = 1'b1;
      cyc(300);
      #1;
      chk("R9 aborted measurement not done", 32'(done), 0);
      pulse_start();
      cyc(2);
      cfg_cnt_en = 1'b0;
      cyc(40);
      cfg_cnt_en = 1'b1;
      cyc(300);
      #1;
      chk("R9 counter stop aborts", 32'(done), 0);

      // R12: edge divider restarts after capture disable
      @(negedge clk);
      gen_on = 1'b0; cfg_sel = 1'b0; cfg_epsc = 2'd1;
      cyc(6);
      man_pulse();
      cfg_cap_en = 1'b0;
      cyc(2);
      cfg_cap_en = 1'b1;
      cyc(2);
      base = snap_total;
      man_pulse();
      chk("R12 first edge after re-enable", 32'(snap_total - base), 0);
      man_pulse();
      chk("R3 second edge captures", 32'(snap_total - base), 1);

      // R11: start in the same cycle as a snapshot
      run_meas(8, 8, 0, 0, 16'hFFFF, 0, 0, "R11 pre-collision");
      seen = 0;
      for (int i = 0; i < 100 && seen == 0; i++) begin
         @(negedge clk);
         #1;
         if (snap_valid) seen = 1;
      end
      repeat (16) @(negedge clk);
      meas_start = 1'b1;
      #1;
      chk("R11 collision provoked", 32'(snap_valid), 1);
      @(negedge clk);
      meas_start = 1'b0;
      for (int i = 0; i < 100 && meas_n < 1; i++) begin
         @(negedge clk);
         #1;
      end
      cyc(3);
      #1;
      chk("R11 colliding snapshot discarded", 32'(done), 0);
      wait_done("R11 collision");
      chk("R11 collision period", 32'(period), 32'(exp_per(rec_r[0], rec_r[1], cfg_rel)));
      chk("R11 collision duty", 32'(duty),
          32'(exp_duty(rec_r[0], rec_f[1], rec_r[1], cfg_rel, 0)));

      // constrained random measurements
      for (int t = 0; t < 12; t++) begin
         int h, l, n, psc, rel, sel;
         h = 2 + int'($urandom % 30);
         l = 2 + int'($urandom % 30);
         n = int'($urandom % 4);
         psc = int'($urandom % 3);
         rel = ($urandom % 2) ? 16'hFFFF : 60 + int'($urandom % 150);
         sel = int'($urandom % 2);
         run_meas(h, l, n, psc, rel, sel, 0, $sformatf("R5 R6 random %0d", t));
      end

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
   end
endmodule